// File: doc/BRIEF.md
# Wide Integer Multiply Unit with Flags

This unit multiplies two 64-bit operands over several clock cycles. It returns the full 128-bit product as a low and a high half, together with the carry and overflow flags that a processor's multiply instructions set. It has three working modes: a one-operand unsigned multiply, a one-operand signed multiply that keeps both halves, and a signed multiply that truncates to the low half. In truncating mode the second operand may instead come from a 32-bit immediate, which is sign-extended first.

Each operand is split into two 32-bit halves. On successive cycles the four 32x32 partial products are added into a 128-bit accumulator, each at the word position given by the sum of its half indices, and carries run on into the higher words. For the signed modes, negative operands are first replaced by their magnitudes. The unsigned product is then negated in a final step when exactly one operand was negative. A start strobe is accepted only when the unit is idle. A one-cycle done pulse marks the cycle in which new results appear, and the results stay on the outputs until the next done.

Top module: `wide_mul_unit`

## Requirements
- R1: In mode 2'b00 (and in mode 2'b11, which acts the same), res_lo is bits 63:0 and res_hi is bits 127:64 of the unsigned product op_a*op_b.
- R2: In the unsigned modes (2'b00, 2'b11), flag_c and flag_o are both 1 exactly when res_hi is nonzero, and both 0 otherwise.
- R3: In mode 2'b01, {res_hi,res_lo} is the 128-bit two's-complement product of op_a and op_b taken as signed values. This includes operands equal to the most negative 64-bit value, whose magnitude is 2^63.
- R4: In mode 2'b01, both flags are 0 when res_hi is all zeros and res_lo bit 63 is 0, or when res_hi is all ones and res_lo bit 63 is 1. Otherwise both flags are 1.
- R5: In mode 2'b10, res_lo is the low 64 bits of the signed product and res_hi is zero. Both flags are 1 exactly when the full signed product differs from the sign extension of res_lo.
- R6: In mode 2'b10 with use_imm=1, the second operand is imm sign-extended from 32 to 64 bits, and op_b is unused. In every other mode, use_imm and imm have no effect.
- R7: If start is high at a rising edge while the unit is idle, done is high for exactly one cycle, beginning at the fifth rising edge after that one, and the new results and flags appear at that same edge. At all other times the outputs hold their values.
- R8: A start seen in the four cycles after an accepted start, and in the cycle before its done, is ignored. A start that is high during the done cycle is accepted as a new operation.
- R9: While reset is asserted, and after it, res_lo, res_hi, flag_c, flag_o and done are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a multiply when idle |
| mode | input | 2 | 00 unsigned wide, 01 signed wide, 10 signed truncating, 11 as 00 |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| use_imm | input | 1 | In mode 10, take the second operand from imm |
| imm | input | 32 | Immediate operand, sign-extended before use |
| res_lo | output | 64 | Low half of the product |
| res_hi | output | 64 | High half of the product (zero in truncating mode) |
| flag_c | output | 1 | Carry flag for the finished operation |
| flag_o | output | 1 | Overflow flag for the finished operation |
| done | output | 1 | One-cycle pulse when results update |

## Verification
Two things can happen in the same cycle: the result of one operation is delivered, and the start of the next is accepted. The bench provokes this by holding start high across a whole operation while changing the operands. The requests made while busy must leave no trace, and the request still present in the done cycle must start a second operation whose result arrives five edges later. A cycle-by-cycle model in the bench tracks both operations and is compared against the outputs and done on every clock.

// File: rtl/wmul_pkg.sv
package wmul_pkg;

  typedef enum logic [1:0] {
    MD_UWIDE  = 2'b00,
    MD_SWIDE  = 2'b01,
    MD_STRUNC = 2'b10,
    MD_UALT   = 2'b11
  } wmul_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PP   = 2'b01,
    ST_FIN  = 2'b10
  } wmul_state_e;

endpackage

// File: rtl/wmul_rst_sync.sv
module wmul_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = sync_q[1];

endmodule

// File: rtl/wmul_abs.sv
module wmul_abs #(
  parameter int W = 64
) (
  input  logic [W-1:0] val,
  input  logic         sgn_en,
  output logic [W-1:0] mag,
  output logic         neg
);

  always_comb begin
    neg = sgn_en & val[W-1];
    mag = neg ? (~val + W'(1)) : val;
  end

endmodule

// File: rtl/wmul_accum.sv
module wmul_accum #(
  parameter int OP_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step_en,
  input  logic [1:0]        step_idx,
  input  logic [OP_W-1:0]   mag_a,
  input  logic [OP_W-1:0]   mag_b,
  output logic [2*OP_W-1:0] acc
);

  localparam int HALF_W = OP_W / 2;
  localparam int PROD_W = 2 * OP_W;

  logic [HALF_W-1:0] a_half [2];
  logic [HALF_W-1:0] b_half [2];

  for (genvar g = 0; g < 2; g++) begin : g_split
    assign a_half[g] = mag_a[g*HALF_W +: HALF_W];
    assign b_half[g] = mag_b[g*HALF_W +: HALF_W];
  end

  logic [HALF_W-1:0] a_sel, b_sel;
  logic [OP_W-1:0]   pp;
  logic [1:0]        word_off;
  logic [PROD_W-1:0] pp_shift;
  logic [PROD_W-1:0] acc_q, acc_d;

  always_comb begin
    a_sel    = a_half[step_idx[1]];
    b_sel    = b_half[step_idx[0]];
    pp       = {{HALF_W{1'b0}}, a_sel} * {{HALF_W{1'b0}}, b_sel};
    word_off = {1'b0, step_idx[1]} + {1'b0, step_idx[0]};
    pp_shift = {{OP_W{1'b0}}, pp} << (int'(word_off) * HALF_W);
    if (clr) begin
      acc_d = '0;
    end else begin
      acc_d = acc_q + pp_shift;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clr || step_en) begin
      acc_q <= acc_d;
    end
  end

  assign acc = acc_q;

endmodule

// File: rtl/wmul_flags.sv
module wmul_flags
  import wmul_pkg::*;
#(
  parameter int OP_W = 64
) (
  input  logic [2*OP_W-1:0] acc,
  input  logic              neg,
  input  wmul_mode_e        mode,
  output logic [OP_W-1:0]   lo,
  output logic [OP_W-1:0]   hi,
  output logic              flag
);

  localparam int PROD_W = 2 * OP_W;

  logic [PROD_W-1:0] prod;
  logic [OP_W-1:0]   hi_full;
  logic              not_sext;

  always_comb begin
    prod     = neg ? (~acc + PROD_W'(1)) : acc;
    lo       = prod[OP_W-1:0];
    hi_full  = prod[PROD_W-1:OP_W];
    not_sext = (hi_full != {OP_W{lo[OP_W-1]}});
    unique case (mode)
      MD_SWIDE: begin
        hi   = hi_full;
        flag = not_sext;
      end
      MD_STRUNC: begin
        hi   = '0;
        flag = not_sext;
      end
      default: begin
        hi   = hi_full;
        flag = |hi_full;
      end
    endcase
  end

endmodule

// File: rtl/wide_mul_unit.sv
module wide_mul_unit
  import wmul_pkg::*;
#(
  parameter int OP_W  = 64,
  parameter int IMM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  input  logic             use_imm,
  input  logic [IMM_W-1:0] imm,
  output logic [OP_W-1:0]  res_lo,
  output logic [OP_W-1:0]  res_hi,
  output logic             flag_c,
  output logic             flag_o,
  output logic             done
);

  localparam int PROD_W   = 2 * OP_W;
  localparam int LAST_STEP = 3;

  logic rst_core_n;

  wmul_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  // operand selection and magnitude
  wmul_mode_e      mode_e;
  logic            sgn_mode;
  logic [OP_W-1:0] opnd [2];
  logic [OP_W-1:0] mag  [2];
  logic            negv [2];

  always_comb begin
    mode_e   = wmul_mode_e'(mode);
    sgn_mode = (mode_e == MD_SWIDE) || (mode_e == MD_STRUNC);
    opnd[0]  = op_a;
    if ((mode_e == MD_STRUNC) && use_imm) begin
      opnd[1] = {{(OP_W-IMM_W){imm[IMM_W-1]}}, imm};
    end else begin
      opnd[1] = op_b;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_abs
    wmul_abs #(.W(OP_W)) u_abs (
      .val    (opnd[g]),
      .sgn_en (sgn_mode),
      .mag    (mag[g]),
      .neg    (negv[g])
    );
  end

  // control
  wmul_state_e st_q, st_d;
  logic [1:0]  step_q, step_d;
  logic        load, step_en, out_en;

  always_comb begin
    st_d    = st_q;
    step_d  = step_q;
    load    = 1'b0;
    step_en = 1'b0;
    out_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          load   = 1'b1;
          step_d = 2'd0;
          st_d   = ST_PP;
        end
      end
      ST_PP: begin
        step_en = 1'b1;
        if (step_q == 2'(LAST_STEP)) begin
          st_d = ST_FIN;
        end else begin
          step_d = step_q + 2'd1;
        end
      end
      ST_FIN: begin
        out_en = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q   <= ST_IDLE;
      step_q <= 2'd0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
    end
  end

  // captured operands
  logic [OP_W-1:0] mag_a_q, mag_b_q;
  logic            neg_q;
  wmul_mode_e      mode_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      mag_a_q <= '0;
      mag_b_q <= '0;
      neg_q   <= 1'b0;
      mode_q  <= MD_UWIDE;
    end else if (load) begin
      mag_a_q <= mag[0];
      mag_b_q <= mag[1];
      neg_q   <= negv[0] ^ negv[1];
      mode_q  <= mode_e;
    end
  end

  logic [PROD_W-1:0] acc;

  wmul_accum #(.OP_W(OP_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clr      (load),
    .step_en  (step_en),
    .step_idx (step_q),
    .mag_a    (mag_a_q),
    .mag_b    (mag_b_q),
    .acc      (acc)
  );

  logic [OP_W-1:0] lo_d, hi_d;
  logic            flag_d;

  wmul_flags #(.OP_W(OP_W)) u_flags (
    .acc  (acc),
    .neg  (neg_q),
    .mode (mode_q),
    .lo   (lo_d),
    .hi   (hi_d),
    .flag (flag_d)
  );

  // result registers
  logic [OP_W-1:0] lo_q, hi_q;
  logic            fc_q, fo_q, done_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      lo_q <= '0;
      hi_q <= '0;
      fc_q <= 1'b0;
      fo_q <= 1'b0;
    end else if (out_en) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
      fc_q <= flag_d;
      fo_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= out_en;
    end
  end

  assign res_lo = lo_q;
  assign res_hi = hi_q;
  assign flag_c = fc_q;
  assign flag_o = fo_q;
  assign done   = done_q;

endmodule

// File: rtl/wmul_checker.sv
module wmul_checker #(
  parameter int OP_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [1:0]      mode,
  input logic            done,
  input logic [OP_W-1:0] res_lo,
  input logic [OP_W-1:0] res_hi,
  input logic            flag_c,
  input logic            flag_o
);

  logic [2:0] ck_cnt;
  logic [1:0] ck_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_cnt  <= 3'd0;
      ck_mode <= 2'b00;
    end else if (ck_cnt == 3'd0) begin
      if (start) begin
        ck_cnt  <= 3'd5;
        ck_mode <= mode;
      end
    end else begin
      ck_cnt <= ck_cnt - 3'd1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_cnt == 3'd1) |=> done); // R7
  AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_cnt > 3'd1) |=> !done); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({res_lo, res_hi, flag_c, flag_o})); // R7
  AST_UNSIGNED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (ck_mode == 2'b00 || ck_mode == 2'b11)) |-> (flag_c == (res_hi != '0))); // R2
  AST_SIGNED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ck_mode == 2'b01) |-> (flag_o == (res_hi != {OP_W{res_lo[OP_W-1]}}))); // R4
  AST_TRUNC_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ck_mode == 2'b10) |-> (res_hi == '0)); // R5

endmodule

bind wide_mul_unit wmul_checker #(.OP_W(OP_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_core_n),
  .start  (start),
  .mode   (mode),
  .done   (done),
  .res_lo (res_lo),
  .res_hi (res_hi),
  .flag_c (flag_c),
  .flag_o (flag_o)
);

// File: tb/wide_mul_unit_bench.sv
`timescale 1ns/1ps
module wide_mul_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  mode;
  logic [63:0] op_a, op_b;
  logic        use_imm;
  logic [31:0] imm;
  logic [63:0] res_lo, res_hi;
  logic        flag_c, flag_o, done;

  always #5 clk = ~clk;

  wide_mul_unit u_wide_mul_unit (
    .clk (clk), .rst_n (rst_n), .start (start), .mode (mode),
    .op_a (op_a), .op_b (op_b), .use_imm (use_imm), .imm (imm),
    .res_lo (res_lo), .res_hi (res_hi), .flag_c (flag_c),
    .flag_o (flag_o), .done (done)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  logic  chk_en = 1'b0;
  string cur_tag = "R1";

  // reference model
  int          m_cnt;
  logic        m_done;
  logic [63:0] m_lo, m_hi, p_lo, p_hi;
  logic        m_flag, p_flag;
  string       m_tag = "R1", m_ftag = "R2", p_tag, p_ftag;

  task automatic model_calc(input logic [1:0] md, input logic [63:0] a,
                            input logic [63:0] b, input logic ui, input logic [31:0] im);
    logic [63:0]  bb;
    logic [127:0] up;
    logic signed [127:0] sp;
    bb = (md == 2'b10 && ui) ? {{32{im[31]}}, im} : b;
    up = {64'd0, a} * {64'd0, bb};
    sp = $signed({{64{a[63]}}, a}) * $signed({{64{bb[63]}}, bb});
    p_tag = cur_tag;
    if (md == 2'b01 || md == 2'b10) begin
      p_lo   = sp[63:0];
      p_hi   = (md == 2'b10) ? 64'd0 : sp[127:64];
      p_flag = (sp != {{64{sp[63]}}, sp[63:0]});
      p_ftag = (md == 2'b01) ? "R4" : cur_tag;
    end else begin
      p_lo   = up[63:0];
      p_hi   = up[127:64];
      p_flag = (up[127:64] != 64'd0);
      p_ftag = "R2";
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 1'b0; m_lo = '0; m_hi = '0; m_flag = 1'b0;
    end else begin
      m_done = 1'b0;
      if (m_cnt == 0) begin
        if (start) begin
          model_calc(mode, op_a, op_b, use_imm, imm);
          m_cnt = 5;
        end
      end else begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_done = 1'b1; m_lo = p_lo; m_hi = p_hi; m_flag = p_flag;
          m_tag = p_tag; m_ftag = p_ftag;
        end
      end
    end
  end

  task automatic check64(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      check64("R7", "done", 64'(done), 64'(m_done));
      check64(m_tag, "res_lo", res_lo, m_lo);
      check64(m_tag, "res_hi", res_hi, m_hi);
      check64(m_ftag, "flag_c", 64'(flag_c), 64'(m_flag));
      check64(m_ftag, "flag_o", 64'(flag_o), 64'(m_flag));
    end
  end

  task automatic run_op(input string tag, input logic [1:0] md, input logic [63:0] a,
                        input logic [63:0] b, input logic ui, input logic [31:0] im);
    @(negedge clk); #1;
    cur_tag = tag; mode = md; op_a = a; op_b = b; use_imm = ui; imm = im; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 2'b00; op_a = '0; op_b = '0;
    use_imm = 1'b0; imm = '0;
    repeat (4) @(negedge clk);
    // R9 reset state
    check64("R9", "reset outputs", {res_lo[31:0] | res_hi[31:0], 31'd0, done},
            64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_en = 1'b1;

    // R1 / R2 unsigned
    run_op("R1", 2'b00, 64'd3, 64'd5, 1'b0, 32'd0);
    run_op("R1", 2'b00, ALL1, ALL1, 1'b0, 32'd0);
    run_op("R1", 2'b00, 64'h1_0000_0000, 64'h1_0000_0000, 1'b0, 32'd0);
    run_op("R1", 2'b11, 64'hDEAD_BEEF_1234_5678, 64'h0FED_CBA9_8765_4321, 1'b0, 32'd0);
    run_op("R1", 2'b00, 64'd0, ALL1, 1'b0, 32'd0);
    // R3 / R4 signed wide
    run_op("R3", 2'b01, -64'sd3, 64'd7, 1'b0, 32'd0);
    run_op("R3", 2'b01, MINV, MINV, 1'b0, 32'd0);
    run_op("R3", 2'b01, MINV, ALL1, 1'b0, 32'd0);
    run_op("R3", 2'b01, ALL1, ALL1, 1'b0, 32'd0);
    run_op("R3", 2'b01, 64'h1_0000_0000, 64'h8000_0000, 1'b0, 32'd0);
    run_op("R3", 2'b01, MINV, 64'd1, 1'b0, 32'd0);
    // R5 truncating
    run_op("R5", 2'b10, MINV, ALL1, 1'b0, 32'd0);
    run_op("R5", 2'b10, -64'sd5, 64'd6, 1'b0, 32'd0);
    run_op("R5", 2'b10, 64'h7FFF_FFFF_FFFF_FFFF, 64'd2, 1'b0, 32'd0);
    // R6 immediate use and ignore
    run_op("R6", 2'b10, 64'd7, 64'h1234_5678_9ABC_DEF0, 1'b1, 32'hFFFF_FFFE);
    run_op("R6", 2'b10, 64'h4000_0000_0000_0000, 64'd9, 1'b1, 32'h0000_0004);
    run_op("R6", 2'b00, 64'd11, 64'd13, 1'b1, 32'hFFFF_FFFF);
    run_op("R6", 2'b01, -64'sd11, 64'd13, 1'b1, 32'h8000_0000);

    // R8 start held through busy and done cycles, operands changing
    @(negedge clk); #1;
    cur_tag = "R8"; mode = 2'b01; op_a = 64'd100; op_b = -64'sd3; use_imm = 1'b0;
    start = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); #1;
      op_a = op_a + 64'd17; op_b = op_b - 64'd5; mode = 2'(k % 3);
    end
    start = 1'b0;
    repeat (7) @(negedge clk);

    // R7 random operations across modes
    for (int k = 0; k < 40; k++) begin
      logic [1:0] md;
      md = 2'($urandom_range(0, 3));
      run_op((md == 2'b01) ? "R3" : (md == 2'b10) ? "R5" : "R1", md,
             {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom_range(0, 1)),
             $urandom);
    end

    // R9 reset while busy
    @(negedge clk); #1;
    cur_tag = "R9"; mode = 2'b00; op_a = ALL1; op_b = 64'd3; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    @(negedge clk); #1;
    rst_n = 1'b0;
    @(negedge clk);
    check64("R9", "res_lo in reset", res_lo, 64'd0);
    check64("R9", "done in reset", 64'(done), 64'd0);
    #1 rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check64("R9", "done after reset", 64'(done), 64'd0);
    run_op("R1", 2'b00, 64'd6, 64'd7, 1'b0, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL R7 watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule